// File: doc/BRIEF.md
# Fully Associative Data Translation Buffer

This block translates 64-bit virtual data addresses into physical addresses. It does this with a 64-entry fully associative table. A request carries an address, an access kind (load, store or non-faulting load) and a translation index. The index selects which context takes part in the compare: primary, secondary or nucleus. Entries marked global match under any context.

A hit without a fault returns the physical address and the read and write permissions. A lookup that finds nothing reports a miss. A lookup that hits an entry whose attributes forbid the access reports a data access fault or a protection trap. A fault or protection trap records a status word and the faulting address. A fault, a protection trap or a miss loads a tag-access word, so that refill software can locate the page. Entries are written, and read back, through a plain indexed port.

Requests use a valid/ready handshake, and so do responses. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears in the next cycle and stays until `rsp_ready` is seen high. `req_ready` is low only while a response is waiting and `rsp_ready` is low. The enable, context and mode inputs are plain control pins that are sampled when a request is accepted.

Top module: `assoc_dtlb`

## Requirements
- R1: When `mmu_en` is low, an accepted request returns trap code 0 (none), read and write permission 1, and `rsp_pa` equal to the low PA_W bits of the address. No status register changes.
- R2: An entry hits only if all three of these hold:
  - data bit 63 (valid) is set;
  - the address and the tag agree on every bit at or above the page size;
  - data bit 9 (global) is set, or tag bits [12:0] equal the selected context.
  
  The page-size field is data bits [62:61]. Codes 0, 1, 2 and 3 give pages of 8 KiB, 64 KiB, 512 KiB and 4 MiB.
- R3: On a clean hit, `rsp_pa` takes the entry's page bits [40:13] above the page size and the address bits below it.
- R4: The translation index selects the context:
  - 0 (user) and 1 (kernel) use `ctx_primary`, status context type 0;
  - 2 (user) and 3 (kernel) use `ctx_secondary`, status context type 1;
  - 4 and above use context 0, status context type 2.
  
  Indices 0 and 2 are user accesses.
- R5: Three conditions each raise trap code 2 (fault), and each sets its own status bit. Several bits may be set at once.
  - A user access to an entry with data bit 2 (privileged) set sets status bit 7.
  - A non-faulting load (kind 2) to an entry with data bit 7 (side effect) set sets status bit 8.
  - Any other kind (load 0, store 1) to an entry with data bit 8 (no-fault-only) set sets status bit 9.
- R6: A store to an entry with data bit 1 (writable) clear gives trap code 3 (protection) only when no R5 condition holds. A protection trap leaves status bits [9:7] clear.
- R7: A fault or protection trap replaces the status word as follows:
  - bit 0 (valid) is set;
  - bit 1 (overwrite) takes the old bit 0;
  - bit 2 is set for a store and bit 3 for a non-faulting load;
  - bits [5:4] hold the context type;
  - bit 6 holds `priv_mode`.
  
  `fault_addr` takes the full address.
- R8: A fault, a protection trap or a miss (trap code 1) loads `tag_access` with the address, bits [12:0] cleared, OR'd with the context used. A miss leaves `fault_status` and `fault_addr` unchanged.
- R9: A clean hit returns trap code 0, read permission 1 and write permission equal to data bit 1. It sets the entry's used bit (data bit 10). Any trap returns both permissions and `rsp_pa` as 0.
- R10: When several entries hit, the lowest-numbered entry supplies the result.
- R11: `req_ready` is low exactly when `rsp_valid` is high and `rsp_ready` is low. A held response keeps every response field unchanged.
- R12: After reset, the following are all 0: `rsp_valid`, `fault_status`, `fault_addr`, `tag_access` and every entry.
- R13: `fill_en` writes `fill_tag` and `fill_data` into entry `fill_idx` at the clock edge. `ent_rd_tag` and `ent_rd_data` show entry `ent_rd_idx` combinationally. A fill overrides a used-bit update to the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_en | input | 1 | Translation enable |
| ctx_primary | input | CTX_W | Primary context |
| ctx_secondary | input | CTX_W | Secondary context |
| priv_mode | input | 1 | Processor privileged mode, recorded on faults |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_va | input | VA_W | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 non-faulting load |
| req_mmu_idx | input | 3 | Translation index |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_trap | output | 2 | 0 none, 1 miss, 2 fault, 3 protection |
| rsp_pa | output | PA_W | Physical address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| fill_en | input | 1 | Entry write strobe |
| fill_idx | input | log2(N_ENT) | Entry to write |
| fill_tag | input | VA_W | Tag: address bits above 12, context in [12:0] |
| fill_data | input | 64 | Entry attributes and page bits |
| ent_rd_idx | input | log2(N_ENT) | Entry to read |
| ent_rd_tag | output | VA_W | Tag of the entry read |
| ent_rd_data | output | 64 | Data of the entry read |
| fault_status | output | 10 | Fault status word |
| fault_addr | output | VA_W | Address of the last fault |
| tag_access | output | VA_W | Page and context of the last miss or fault |

## Verification
The bench covers several boundary cases:
- **Page sizes.** It uses 4 MiB and 64 KiB pages and addresses just outside them. A wrong size mask would hit a neighbouring page or miss inside a large one.
- **Global entry.** It reaches a global entry under an unrelated context.
- **Duplicate entries.** Two entries cover the same page with different writability. Picking the wrong one shows as a wrong address and write permission.
- **Stacked faults.** A store to a privileged no-fault-only read-only page must report a fault with two bits, not a protection trap.
- **Kernel non-faulting load.** A kernel non-faulting load to that same page must succeed.
- **Status and tag-access words.** Checks cover the overwrite bit, the context type and the used context in `tag_access`. They also check that a miss leaves the status untouched. Mixing up the context source would show in these words.

// File: rtl/assoc_dtlb_pkg.sv
package assoc_dtlb_pkg;
  localparam int ENT_W = 64;
  // entry data bit positions
  localparam int E_VALID  = 63;
  localparam int E_SZ_LO  = 61;
  localparam int E_USED   = 10;
  localparam int E_GLOBAL = 9;
  localparam int E_NFO    = 8;
  localparam int E_SIDEFX = 7;
  localparam int E_PRIV   = 2;
  localparam int E_WRITE  = 1;
  // status word
  localparam int STAT_W   = 10;
  localparam int S_VALID  = 0;
  localparam int S_OVWR   = 1;
  localparam int S_STORE  = 2;
  localparam int S_NFLD   = 3;
  localparam int S_CT_LO  = 4;
  localparam int S_PMODE  = 6;
  localparam int S_FPRIV  = 7;
  localparam int S_FSIDE  = 8;
  localparam int S_FNFO   = 9;

  localparam logic [1:0] KIND_LOAD = 2'd0, KIND_STORE = 2'd1, KIND_NFLOAD = 2'd2;
  localparam logic [1:0] CT_PRIM = 2'd0, CT_SEC = 2'd1, CT_NUC = 2'd2;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_MISS  = 2'd1,
    TRAP_FAULT = 2'd2,
    TRAP_PROT  = 2'd3
  } trap_e;
endpackage

// File: rtl/assoc_dtlb_match.sv
module assoc_dtlb_match #(
  parameter int N_ENT      = 64,
  parameter int VA_W       = 64,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13
) (
  input  logic [VA_W-1:0]  tags  [N_ENT],
  input  logic [N_ENT-1:0] valid,
  input  logic [1:0]       size  [N_ENT],
  input  logic [N_ENT-1:0] glob,
  input  logic [VA_W-1:0]  va,
  input  logic [CTX_W-1:0] ctx,
  output logic [N_ENT-1:0] hit
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic [VA_W-1:0] pmask;
    assign pmask  = {VA_W{1'b1}} << (PAGE_SHIFT + 3 * int'(size[g]));
    assign hit[g] = valid[g] && ((va & pmask) == (tags[g] & pmask)) &&
                    (glob[g] || (tags[g][CTX_W-1:0] == ctx));
  end
endmodule

// File: rtl/assoc_dtlb_pick.sv
module assoc_dtlb_pick #(
  parameter int N_ENT = 64,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] hit,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/assoc_dtlb_eval.sv
module assoc_dtlb_eval
  import assoc_dtlb_pkg::*;
#(
  parameter int PA_W       = 41,
  parameter int PAGE_SHIFT = 13,
  localparam int PPN_W     = PA_W - PAGE_SHIFT
) (
  input  logic             any_hit,
  input  logic [1:0]       kind,
  input  logic             is_user,
  input  logic [1:0]       size,
  input  logic [PPN_W-1:0] ppn,
  input  logic             a_priv,
  input  logic             a_side,
  input  logic             a_nfo,
  input  logic             a_write,
  input  logic [PA_W-1:0]  va_low,
  output trap_e            trap,
  output logic [PA_W-1:0]  pa,
  output logic             wr_ok,
  output logic             f_priv,
  output logic             f_side,
  output logic             f_nfo
);
  logic [PA_W-1:0] pmask;
  logic            faulted;

  assign pmask   = {PA_W{1'b1}} << (PAGE_SHIFT + 3 * int'(size));
  assign pa      = ({ppn, {PAGE_SHIFT{1'b0}}} & pmask) | (va_low & ~pmask);
  assign f_priv  = a_priv && is_user;
  assign f_side  = (kind == KIND_NFLOAD) && a_side;
  assign f_nfo   = (kind != KIND_NFLOAD) && a_nfo;
  assign faulted = f_priv || f_side || f_nfo;
  assign wr_ok   = a_write;

  always_comb begin
    if (!any_hit)                              trap = TRAP_MISS;
    else if (faulted)                          trap = TRAP_FAULT;
    else if (kind == KIND_STORE && !a_write)   trap = TRAP_PROT;
    else                                       trap = TRAP_NONE;
  end
endmodule

// File: rtl/assoc_dtlb.sv
module assoc_dtlb
  import assoc_dtlb_pkg::*;
#(
  parameter int N_ENT      = 64,
  parameter int VA_W       = 64,
  parameter int PA_W       = 41,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13,
  localparam int IW        = $clog2(N_ENT),
  localparam int PPN_W     = PA_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mmu_en,
  input  logic [CTX_W-1:0]   ctx_primary,
  input  logic [CTX_W-1:0]   ctx_secondary,
  input  logic               priv_mode,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic [1:0]         req_kind,
  input  logic [2:0]         req_mmu_idx,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [1:0]         rsp_trap,
  output logic [PA_W-1:0]    rsp_pa,
  output logic               rsp_rd_ok,
  output logic               rsp_wr_ok,
  input  logic               fill_en,
  input  logic [IW-1:0]      fill_idx,
  input  logic [VA_W-1:0]    fill_tag,
  input  logic [ENT_W-1:0]   fill_data,
  input  logic [IW-1:0]      ent_rd_idx,
  output logic [VA_W-1:0]    ent_rd_tag,
  output logic [ENT_W-1:0]   ent_rd_data,
  output logic [STAT_W-1:0]  fault_status,
  output logic [VA_W-1:0]    fault_addr,
  output logic [VA_W-1:0]    tag_access
);
  logic [VA_W-1:0]  tag_q [N_ENT];
  logic [ENT_W-1:0] dat_q [N_ENT];
  logic [1:0]       size_a [N_ENT];
  logic [N_ENT-1:0] valid_v, glob_v, hit_v;

  for (genvar g = 0; g < N_ENT; g++) begin : g_fields
    assign size_a[g]  = dat_q[g][E_SZ_LO+1:E_SZ_LO];
    assign valid_v[g] = dat_q[g][E_VALID];
    assign glob_v[g]  = dat_q[g][E_GLOBAL];
  end

  // context selection from the translation index
  logic [CTX_W-1:0] sel_ctx;
  logic [1:0]       sel_ct;
  logic             is_user;
  always_comb begin
    is_user = (req_mmu_idx == 3'd0) || (req_mmu_idx == 3'd2);
    case (req_mmu_idx)
      3'd0, 3'd1: begin sel_ctx = ctx_primary;   sel_ct = CT_PRIM; end
      3'd2, 3'd3: begin sel_ctx = ctx_secondary; sel_ct = CT_SEC;  end
      default:    begin sel_ctx = '0;            sel_ct = CT_NUC;  end
    endcase
  end

  assoc_dtlb_match #(.N_ENT(N_ENT), .VA_W(VA_W), .CTX_W(CTX_W), .PAGE_SHIFT(PAGE_SHIFT)) u_match (
    .tags(tag_q), .valid(valid_v), .size(size_a), .glob(glob_v),
    .va(req_va), .ctx(sel_ctx), .hit(hit_v)
  );

  logic          any_hit;
  logic [IW-1:0] win;
  assoc_dtlb_pick #(.N_ENT(N_ENT)) u_pick (.hit(hit_v), .any(any_hit), .idx(win));

  logic [ENT_W-1:0] went;
  assign went = dat_q[win];

  trap_e           ev_trap;
  logic [PA_W-1:0] ev_pa;
  logic            ev_wr, f_priv, f_side, f_nfo;
  assoc_dtlb_eval #(.PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_eval (
    .any_hit(any_hit), .kind(req_kind), .is_user(is_user),
    .size(went[E_SZ_LO+1:E_SZ_LO]), .ppn(went[PA_W-1:PAGE_SHIFT]),
    .a_priv(went[E_PRIV]), .a_side(went[E_SIDEFX]), .a_nfo(went[E_NFO]),
    .a_write(went[E_WRITE]), .va_low(req_va[PA_W-1:0]),
    .trap(ev_trap), .pa(ev_pa), .wr_ok(ev_wr),
    .f_priv(f_priv), .f_side(f_side), .f_nfo(f_nfo)
  );

  logic fire, set_used, rec_fault;
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign set_used  = fire && mmu_en && (ev_trap == TRAP_NONE);
  assign rec_fault = fire && mmu_en && (ev_trap == TRAP_FAULT || ev_trap == TRAP_PROT);

  logic [STAT_W-1:0] new_stat;
  always_comb begin
    new_stat                     = '0;
    new_stat[S_VALID]            = 1'b1;
    new_stat[S_OVWR]             = fault_status[S_VALID];
    new_stat[S_STORE]            = (req_kind == KIND_STORE);
    new_stat[S_NFLD]             = (req_kind == KIND_NFLOAD);
    new_stat[S_CT_LO+1:S_CT_LO]  = sel_ct;
    new_stat[S_PMODE]            = priv_mode;
    new_stat[S_FPRIV]            = f_priv;
    new_stat[S_FSIDE]            = f_side;
    new_stat[S_FNFO]             = f_nfo;
  end

  // entry storage: fill wins over used-bit update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (fill_en && fill_idx == IW'(i)) begin
          tag_q[i] <= fill_tag;
          dat_q[i] <= fill_data;
        end else if (set_used && win == IW'(i)) begin
          dat_q[i][E_USED] <= 1'b1;
        end
      end
    end
  end

  assign ent_rd_tag  = tag_q[ent_rd_idx];
  assign ent_rd_data = dat_q[ent_rd_idx];

  trap_e rsp_trap_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_trap_q   <= TRAP_NONE;
      rsp_pa       <= '0;
      rsp_rd_ok    <= 1'b0;
      rsp_wr_ok    <= 1'b0;
      fault_status <= '0;
      fault_addr   <= '0;
      tag_access   <= '0;
    end else begin
      if (fire)           rsp_valid <= 1'b1;
      else if (rsp_ready) rsp_valid <= 1'b0;
      if (fire) begin
        if (!mmu_en) begin
          rsp_trap_q <= TRAP_NONE;
          rsp_pa     <= req_va[PA_W-1:0];
          rsp_rd_ok  <= 1'b1;
          rsp_wr_ok  <= 1'b1;
        end else begin
          rsp_trap_q <= ev_trap;
          rsp_pa     <= (ev_trap == TRAP_NONE) ? ev_pa : '0;
          rsp_rd_ok  <= (ev_trap == TRAP_NONE);
          rsp_wr_ok  <= (ev_trap == TRAP_NONE) && ev_wr;
          if (ev_trap != TRAP_NONE)
            tag_access <= {req_va[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}} | VA_W'(sel_ctx);
        end
      end
      if (rec_fault) begin
        fault_status <= new_stat;
        fault_addr   <= req_va;
      end
    end
  end

  assign rsp_trap = rsp_trap_q;
endmodule

// File: rtl/assoc_dtlb_chk.sv
module assoc_dtlb_chk
  import assoc_dtlb_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int PA_W = 41
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mmu_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_trap,
  input logic [PA_W-1:0]   rsp_pa,
  input logic              rsp_rd_ok,
  input logic              rsp_wr_ok,
  input logic [STAT_W-1:0] fault_status,
  input logic [VA_W-1:0]   fault_addr
);
  assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !mmu_en) |=> (rsp_valid && rsp_trap == TRAP_NONE && rsp_rd_ok && rsp_wr_ok));

  assert_prot_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fault_status) && rsp_trap == TRAP_PROT) |-> (fault_status[S_FNFO:S_FPRIV] == 3'b000));

  assert_status_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_trap == TRAP_FAULT || rsp_trap == TRAP_PROT)) |-> fault_status[S_VALID]);

  assert_miss_keeps_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fault_status) || !$stable(fault_addr)) |-> (rsp_trap == TRAP_FAULT || rsp_trap == TRAP_PROT));

  assert_trap_no_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap != TRAP_NONE) |-> (!rsp_rd_ok && !rsp_wr_ok));

  assert_hit_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap == TRAP_NONE) |-> rsp_rd_ok);

  assert_stall_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_hold_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_trap) && $stable(rsp_wr_ok)));
endmodule

bind assoc_dtlb assoc_dtlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_trap(rsp_trap), .rsp_pa(rsp_pa), .rsp_rd_ok(rsp_rd_ok),
  .rsp_wr_ok(rsp_wr_ok), .fault_status(fault_status), .fault_addr(fault_addr)
);

// File: tb/assoc_dtlb_tb.sv
module assoc_dtlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mmu_en = 1'b1;
  logic [12:0] ctx_primary = 13'h005;
  logic [12:0] ctx_secondary = 13'h00A;
  logic        priv_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic [2:0]  req_mmu_idx = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_trap;
  logic [40:0] rsp_pa;
  logic        rsp_rd_ok, rsp_wr_ok;
  logic        fill_en = 1'b0;
  logic [5:0]  fill_idx = '0;
  logic [63:0] fill_tag = '0;
  logic [63:0] fill_data = '0;
  logic [5:0]  ent_rd_idx = '0;
  logic [63:0] ent_rd_tag, ent_rd_data;
  logic [9:0]  fault_status;
  logic [63:0] fault_addr, tag_access;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assoc_dtlb u_dut (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .ctx_primary(ctx_primary),
    .ctx_secondary(ctx_secondary), .priv_mode(priv_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_kind(req_kind), .req_mmu_idx(req_mmu_idx), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_trap(rsp_trap), .rsp_pa(rsp_pa),
    .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok), .fill_en(fill_en),
    .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
    .ent_rd_idx(ent_rd_idx), .ent_rd_tag(ent_rd_tag), .ent_rd_data(ent_rd_data),
    .fault_status(fault_status), .fault_addr(fault_addr), .tag_access(tag_access)
  );

  // entry data: valid 63, size [62:61], page [40:13], global 9, nfo 8, side 7, priv 2, write 1
  function automatic logic [63:0] mk(input logic v, input logic [1:0] sz, input logic [40:0] pa,
                                     input logic g, input logic nfo, input logic se,
                                     input logic pv, input logic w);
    return {v, sz, 20'b0, pa[40:13], 2'b0, 1'b0, g, nfo, se, 4'b0, pv, w, 1'b0};
  endfunction

  function automatic logic [63:0] mkt(input logic [63:0] va, input logic [12:0] ctx);
    return {va[63:13], ctx};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int idx, input logic [63:0] t, input logic [63:0] d);
    @(negedge clk);
    fill_en = 1'b1; fill_idx = 6'(idx); fill_tag = t; fill_data = d;
    @(posedge clk);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic lookup(input logic [63:0] va, input logic [1:0] kind,
                        input logic [2:0] idx, input logic pm);
    @(negedge clk);
    req_va = va; req_kind = kind; req_mmu_idx = idx; priv_mode = pm;
    rsp_ready = 1'b1; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  kind;
    logic [2:0]  idx;
    logic        pm;
    logic [1:0]  trap;
    logic [40:0] pa;
    logic        wr;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{64'h0000_0000_1000_0ABC, 2'd0, 3'd1, 1'b0, 2'd0, 41'h0_8000_2ABC, 1'b1}, // R3 8K hit
    '{64'h0000_0000_1000_1FFF, 2'd1, 3'd0, 1'b0, 2'd0, 41'h0_8000_3FFF, 1'b1}, // R9 store ok
    '{64'h0000_0000_3000_0010, 2'd0, 3'd0, 1'b0, 2'd0, 41'h1_0000_0010, 1'b0}, // R2 global
    '{64'h0000_0000_3000_0010, 2'd1, 3'd0, 1'b0, 2'd3, 41'h0,          1'b0}, // R6 prot
    '{64'h0000_0000_4012_3456, 2'd0, 3'd2, 1'b0, 2'd0, 41'h1_0052_3456, 1'b1}, // R2 4M sec
    '{64'h0000_0000_4012_3456, 2'd0, 3'd0, 1'b0, 2'd1, 41'h0,          1'b0}, // R4 wrong ctx
    '{64'h0000_0000_4012_3456, 2'd0, 3'd3, 1'b0, 2'd0, 41'h1_0052_3456, 1'b1}, // R4 kern sec
    '{64'h0000_0000_7000_0008, 2'd0, 3'd0, 1'b0, 2'd2, 41'h0,          1'b0}, // R5 user priv
    '{64'h0000_0000_7000_0008, 2'd0, 3'd1, 1'b0, 2'd0, 41'h0_0070_0008, 1'b1}, // R5 kernel ok
    '{64'h0000_0000_8000_0004, 2'd2, 3'd1, 1'b0, 2'd2, 41'h0,          1'b0}, // R5 nf side
    '{64'h0000_0000_8000_0004, 2'd0, 3'd1, 1'b0, 2'd0, 41'h0_0080_0004, 1'b1}, // R5 load side
    '{64'h0000_0000_9000_0000, 2'd1, 3'd0, 1'b0, 2'd2, 41'h0,          1'b0}, // R6 fault over prot
    '{64'h0000_0000_9000_0000, 2'd2, 3'd1, 1'b0, 2'd0, 41'h0_0090_0000, 1'b0}, // R5 nf on nfo ok
    '{64'h0000_0000_A000_0020, 2'd0, 3'd4, 1'b0, 2'd0, 41'h0_00A0_0020, 1'b0}, // R4 nucleus
    '{64'h0000_0000_A000_0020, 2'd0, 3'd1, 1'b0, 2'd1, 41'h0,          1'b0}, // R4 primary miss
    '{64'h0000_0000_C000_0000, 2'd0, 3'd1, 1'b0, 2'd1, 41'h0,          1'b0}, // R2 invalid entry
    '{64'h0000_0000_B000_F123, 2'd0, 3'd1, 1'b0, 2'd0, 41'h0_0005_F123, 1'b0}, // R2 64K
    '{64'h0000_0000_B001_0000, 2'd0, 3'd1, 1'b0, 2'd1, 41'h0,          1'b0}, // R2 beyond 64K
    '{64'h0000_0000_5000_0100, 2'd0, 3'd1, 1'b0, 2'd0, 41'h0_0004_0100, 1'b1}  // R10 lowest wins
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check("R12 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R12 status", 64'(fault_status), 64'd0);
    check("R12 far", fault_addr, 64'd0);
    check("R12 tag_access", tag_access, 64'd0);
    check("R12 entry", ent_rd_data, 64'd0);
    check("R11 ready idle", 64'(req_ready), 64'd1);
    rst_n = 1'b1;

    fill(0,  mkt(64'hC000_0000, 13'h05), mk(1'b0, 2'd0, 41'h0_00C0_0000, 0, 0, 0, 0, 1));
    fill(1,  mkt(64'h1000_0000, 13'h05), mk(1'b1, 2'd0, 41'h0_8000_2000, 0, 0, 0, 0, 1));
    fill(3,  mkt(64'h3000_0000, 13'h1F), mk(1'b1, 2'd0, 41'h1_0000_0000, 1, 0, 0, 0, 0));
    fill(4,  mkt(64'h4000_0000, 13'h0A), mk(1'b1, 2'd3, 41'h1_0040_0000, 0, 0, 0, 0, 1));
    fill(5,  mkt(64'h5000_0000, 13'h05), mk(1'b1, 2'd0, 41'h0_0004_0000, 0, 0, 0, 0, 1));
    fill(6,  mkt(64'h5000_0000, 13'h05), mk(1'b1, 2'd0, 41'h0_0006_0000, 0, 0, 0, 0, 0));
    fill(7,  mkt(64'h7000_0000, 13'h05), mk(1'b1, 2'd0, 41'h0_0070_0000, 0, 0, 0, 1, 1));
    fill(8,  mkt(64'h8000_0000, 13'h05), mk(1'b1, 2'd0, 41'h0_0080_0000, 0, 0, 1, 0, 1));
    fill(9,  mkt(64'h9000_0000, 13'h05), mk(1'b1, 2'd0, 41'h0_0090_0000, 0, 1, 0, 1, 0));
    fill(10, mkt(64'hA000_0000, 13'h00), mk(1'b1, 2'd0, 41'h0_00A0_0000, 0, 0, 0, 0, 0));
    fill(12, mkt(64'h6000_0000, 13'h0A), mk(1'b1, 2'd0, 41'h0_0060_0000, 0, 0, 0, 1, 0));
    fill(13, mkt(64'hE000_0000, 13'h00), mk(1'b1, 2'd0, 41'h0_00E0_0000, 0, 1, 0, 0, 0));
    fill(63, mkt(64'hB000_0000, 13'h05), mk(1'b1, 2'd1, 41'h0_0005_0000, 0, 0, 0, 0, 0));

    ent_rd_idx = 6'd1;
    #0;
    check("R13 fill tag readback", ent_rd_tag, mkt(64'h1000_0000, 13'h05));

    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i].va, VEC[i].kind, VEC[i].idx, VEC[i].pm);
      check($sformatf("R2/R3/R5/R9 vec%0d trap", i), 64'(rsp_trap), 64'(VEC[i].trap));
      check($sformatf("R3 vec%0d pa", i), 64'(rsp_pa), 64'(VEC[i].pa));
      check($sformatf("R9 vec%0d wr", i), 64'(rsp_wr_ok), 64'(VEC[i].wr));
      check($sformatf("R9 vec%0d rd", i), 64'(rsp_rd_ok), 64'(VEC[i].trap == 2'd0));
    end

    // R7 stacked fault bits with overwrite
    lookup(64'h9000_0000, 2'd1, 3'd0, 1'b0);
    check("R7 status stacked", 64'(fault_status), 64'h287);
    check("R7 far", fault_addr, 64'h9000_0000);
    check("R8 tag_access fault", tag_access, 64'h9000_0005);

    // R8 miss keeps status
    lookup(64'hD000_1234, 2'd0, 3'd2, 1'b0);
    check("R8 miss trap", 64'(rsp_trap), 64'd1);
    check("R8 tag_access miss", tag_access, 64'hD000_000A);
    check("R8 status kept", 64'(fault_status), 64'h287);
    check("R8 far kept", fault_addr, 64'h9000_0000);

    // R6/R7 protection with privileged mode
    lookup(64'h3000_0040, 2'd1, 3'd1, 1'b1);
    check("R6 prot trap", 64'(rsp_trap), 64'd3);
    check("R7 prot status", 64'(fault_status), 64'h47);
    check("R8 tag uses selected ctx", tag_access, 64'h3000_0005);

    // R5/R7 non-faulting load to side-effect page
    lookup(64'h8000_0000, 2'd2, 3'd1, 1'b1);
    check("R7 nf status", 64'(fault_status), 64'h14B);

    // R4 nucleus context type
    lookup(64'hE000_0010, 2'd0, 3'd4, 1'b0);
    check("R4 nucleus status", 64'(fault_status), 64'h223);
    check("R4 nucleus tag", tag_access, 64'hE000_0000);

    // R4 secondary context type
    lookup(64'h6000_0000, 2'd0, 3'd2, 1'b0);
    check("R4 secondary status", 64'(fault_status), 64'h093);
    check("R4 secondary tag", tag_access, 64'h6000_000A);

    // R9 used bits
    ent_rd_idx = 6'd1;  #0;
    check("R9 used set e1", ent_rd_data, mk(1'b1, 2'd0, 41'h0_8000_2000, 0, 0, 0, 0, 1) | 64'h400);
    ent_rd_idx = 6'd6;  #0;
    check("R10 loser unused e6", ent_rd_data, mk(1'b1, 2'd0, 41'h0_0006_0000, 0, 0, 0, 0, 0));
    ent_rd_idx = 6'd63; #0;
    check("R9 used set e63", ent_rd_data, mk(1'b1, 2'd1, 41'h0_0005_0000, 0, 0, 0, 0, 0) | 64'h400);

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1;
    req_va = 64'h1000_0ABC; req_kind = 2'd0; req_mmu_idx = 3'd1;
    @(posedge clk);
    @(negedge clk);
    req_va = 64'h5000_0100;
    check("R11 ready low", 64'(req_ready), 64'd0);
    repeat (2) @(negedge clk);
    check("R11 held pa", 64'(rsp_pa), 64'h0_8000_2ABC);
    check("R11 held valid", 64'(rsp_valid), 64'd1);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next accepted", 64'(rsp_pa), 64'h0_0004_0100);

    // R1 translation disabled
    @(negedge clk);
    mmu_en = 1'b0;
    lookup(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 3'd0, 1'b0);
    check("R1 pa", 64'(rsp_pa), 64'h1FF_FFFF_FFFF);
    check("R1 perms", 64'({rsp_rd_ok, rsp_wr_ok, rsp_trap}), 64'b1100);
    check("R1 status kept", 64'(fault_status), 64'h093);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule